// File: doc/BRIEF.md
# Multi-Channel Single-Edge Quadrature Position Counter

This block keeps a signed position for several incremental encoders at once. Each encoder supplies a phase A and a phase B line. Both lines pass through a two-flop synchronizer inside the block. Each channel then watches its synchronized phase A for rising edges, and steps its count by one for each complete A cycle. The sign of the step is taken from phase B.

The direction decision reads the synchronized phase B vector in the same clock cycle that the phase A rising edge is detected. All channels read one shared B vector, so every channel decides in parallel and no channel waits on another. After a channel counts, it disarms. It rearms only when phase A falls, so each A cycle yields exactly one step.

A synchronous clear input zeroes every count and arms every channel. Reset is asynchronous and active low. The block releases reset internally on a clock edge.

Top module: `qenc_counter`

## Requirements
- R1: A counted rising edge of phase A while phase B is 1 adds one to that channel's count.
- R2: A counted rising edge of phase A while phase B is 0 subtracts one from that channel's count.
- R3: Direction comes from the synchronized phase B of the clock cycle in which the A rise is detected. A B change applied on the same clock as the A rise is used. A B change applied one clock after the A rise is not used. A count change appears at the output on the third rising clock after the A change at the pin.
- R4: While phase A stays high, the count does not change, whatever phase B does. A falling A does not change the count. Only the next rise after a fall counts again.
- R5: Every channel counts its own edges in parallel. Simultaneous edges on several channels each step their own count by their own phase B.
- R6: The count is a COUNT_W-bit two's complement value that wraps: max + 1 gives min, and min - 1 gives max.
- R7: While clr_i is 1, all counts go to 0 on the next clock and every channel is armed. Clear takes priority over an edge counted in the same cycle.
- R8: After reset, every count reads 0 and every channel is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all counts |
| enc_a_i | input | CHANNELS | Phase A per channel, asynchronous |
| enc_b_i | input | CHANNELS | Phase B per channel, asynchronous |
| count_o | output | CHANNELS x COUNT_W | Signed count per channel |

## Verification
The bench builds the block with CHANNELS=3 and COUNT_W=6. With three channels, simultaneous edges can have mixed phase B levels. With a six-bit count, both wrap boundaries (+31 to -32 and back) are reached in a few dozen steps. Directed cases cover phase B changing on the same clock as the A rise and one clock after it, clear over a pending edge, and B wiggling while A is held high. Random multi-channel pulses then run against a modular expected count.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Step choice for one channel: a counted edge uses the phase B snapshot.
  function automatic step_e step_pick(input logic rise, input logic armed,
                                      input logic b_snap);
    if (rise && armed) return b_snap ? STEP_UP : STEP_DOWN;
    return STEP_HOLD;
  endfunction

endpackage

// File: rtl/qenc_rst_sync.sv
module qenc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/qenc_chan.sv
module qenc_chan
  import qenc_pkg::*;
#(
  parameter int unsigned COUNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               a_sync_i,
  input  logic               b_snap_i,
  output logic [COUNT_W-1:0] count_o
);
  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

  logic               a_prev_q;
  logic               armed_q, armed_d;
  logic [COUNT_W-1:0] count_q, count_d;
  logic               rise, fall;
  step_e              step;

  // Edge detection on the synchronized phase A
  assign rise = a_sync_i & ~a_prev_q;
  assign fall = ~a_sync_i & a_prev_q;
  assign step = step_pick(rise, armed_q, b_snap_i);

  // Next-state logic
  always_comb begin
    count_d = count_q;
    armed_d = armed_q;
    if (clr_i) begin
      count_d = '0;
      armed_d = 1'b1;
    end else begin
      unique case (step)
        STEP_UP:   count_d = count_q + ONE;
        STEP_DOWN: count_d = count_q - ONE;
        default:   count_d = count_q;
      endcase
      if (step != STEP_HOLD) armed_d = 1'b0;
      else if (fall)         armed_d = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_prev_q <= 1'b0;
      armed_q  <= 1'b1;
      count_q  <= '0;
    end else begin
      a_prev_q <= a_sync_i;
      armed_q  <= armed_d;
      count_q  <= count_d;
    end
  end

  assign count_o = count_q;

  // Assertions
  p_up_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && armed_q && !clr_i && b_snap_i) |=> (count_q == $past(count_q) + ONE));

  p_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && armed_q && !clr_i && !b_snap_i) |=> (count_q == $past(count_q) - ONE));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise && !clr_i) |=> $stable(count_q));

  p_disarm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && armed_q && !clr_i) |=> !armed_q);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_q == '0 && armed_q));

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int unsigned CHANNELS = 4,
  parameter int unsigned COUNT_W  = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clr_i,
  input  logic [CHANNELS-1:0]               enc_a_i,
  input  logic [CHANNELS-1:0]               enc_b_i,
  output logic [CHANNELS-1:0][COUNT_W-1:0]  count_o
);
  logic                rst_n;
  logic [CHANNELS-1:0] a_sync;
  logic [CHANNELS-1:0] b_snap;

  qenc_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  qenc_sync #(.WIDTH(CHANNELS)) u_sync_a (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (enc_a_i),
    .q_o    (a_sync)
  );

  // One shared phase B vector: every channel reads it in the same cycle.
  qenc_sync #(.WIDTH(CHANNELS)) u_sync_b (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (enc_b_i),
    .q_o    (b_snap)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    qenc_chan #(.COUNT_W(COUNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .clr_i    (clr_i),
      .a_sync_i (a_sync[c]),
      .b_snap_i (b_snap[c]),
      .count_o  (count_o[c])
    );
  end

  p_reset_r8: assert property (@(posedge clk_i)
    $rose(rst_n) |-> (count_o == '0));

endmodule

// File: tb/qenc_counter_tb_top.sv
module qenc_counter_tb_top;
  localparam int CH = 3;
  localparam int W  = 6;

  logic clk, rst_n, clr;
  logic [CH-1:0] enc_a, enc_b;
  logic [CH-1:0][W-1:0] count;
  logic [W-1:0] exp_q [CH];
  int total, bad;
  bit done;

  qenc_counter #(.CHANNELS(CH), .COUNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .enc_a_i(enc_a), .enc_b_i(enc_b), .count_o(count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W-1:0] stepped(logic [W-1:0] v, logic up);
    return up ? v + W'(1) : v - W'(1);
  endfunction

  task automatic chk(int ch, logic [W-1:0] expv, string req);
    total++;
    if (count[ch] !== expv) begin
      bad++;
      $display("FAIL %s ch%0d got %0d expected %0d", req, ch, count[ch], expv);
    end
  endtask

  task automatic chk_all(string req);
    for (int c = 0; c < CH; c++) chk(c, exp_q[c], req);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Full A cycle on the channels in mask; B applied with the A rise.
  task automatic pulse(logic [CH-1:0] mask, logic [CH-1:0] bv, bit wiggle);
    enc_b = bv;
    enc_a = enc_a | mask;
    cyc(5);
    if (wiggle) begin
      for (int k = 0; k < 4; k++) begin
        enc_b = CH'($urandom);
        cyc(1);
      end
    end
    enc_a = '0;
    cyc(5);
    for (int c = 0; c < CH; c++)
      if (mask[c]) exp_q[c] = stepped(exp_q[c], bv[c]);
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; clr = 1'b0; enc_a = '0; enc_b = '0;
    for (int c = 0; c < CH; c++) exp_q[c] = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    chk_all("R8");

    // R1 / R2 basic directions
    pulse(3'b001, 3'b001, 0); chk(0, exp_q[0], "R1");
    pulse(3'b001, 3'b000, 0); chk(0, exp_q[0], "R2");
    pulse(3'b001, 3'b000, 0); chk(0, 6'h3F, "R2");

    // R3 latency: change appears on the third rising edge after the pin change
    enc_b = 3'b010; enc_a = 3'b010;
    cyc(2); chk(1, 6'h00, "R3");
    cyc(1); chk(1, 6'h01, "R3");
    // B change one clock after the A rise is not used
    enc_a = 3'b000; cyc(5);
    enc_b = 3'b010; enc_a = 3'b010; cyc(1);
    enc_b = 3'b000; cyc(5);
    chk(1, 6'h02, "R3");
    enc_a = 3'b000; cyc(5);
    exp_q[1] = 6'h02;

    // R4: B wiggling while A is high, and the A fall, leave the count alone
    pulse(3'b100, 3'b100, 1); chk(2, exp_q[2], "R4");
    enc_a = 3'b100; enc_b = 3'b100; cyc(5);
    for (int k = 0; k < 6; k++) begin enc_b = CH'(k); cyc(2); end
    exp_q[2] = stepped(exp_q[2], 1'b1);
    chk(2, exp_q[2], "R4");
    enc_a = '0; cyc(5); chk(2, exp_q[2], "R4");

    // R5: simultaneous edges with mixed B levels
    pulse(3'b111, 3'b101, 0); chk_all("R5");
    pulse(3'b111, 3'b010, 0); chk_all("R5");

    // R7: clear held over a pending edge
    enc_b = 3'b111; enc_a = 3'b111; clr = 1'b1;
    cyc(5); clr = 1'b0;
    for (int c = 0; c < CH; c++) exp_q[c] = '0;
    chk_all("R7");
    enc_a = '0; cyc(5);
    pulse(3'b001, 3'b001, 0); chk(0, 6'h01, "R7");

    // R6: wrap at both ends on channel 1
    for (int k = 0; k < 31; k++) pulse(3'b010, 3'b010, 0);
    chk(1, 6'h1F, "R6");
    pulse(3'b010, 3'b010, 0); chk(1, 6'h20, "R6");
    pulse(3'b010, 3'b000, 0); chk(1, 6'h1F, "R6");

    // Random multi-channel traffic
    for (int it = 0; it < 80; it++) begin
      pulse(CH'($urandom), CH'($urandom), bit'($urandom));
      chk_all("R5");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule